// File: doc/BRIEF.md
# UART Serial Transmit Engine

This block is the transmit side of a UART. When its transmit FIFO holds a byte, it pops that byte and sends it as a frame on a single output line that rests high. Each frame has a low start bit, then 7 or 8 data bits sent least significant bit first, then an optional odd or even parity bit, then a stop period of one, one and a half or two bit periods.

All bit timing comes from a tick whose rate is the clock divided by a shared 16-bit divisor. One bit period is 16 ticks. The format inputs can change at any time. They are captured when a byte is popped, so a change has no effect on a frame that is already on the line. A done output tells the system that the FIFO is empty and the last stop period has ended.

The FIFO storage, the register interface and flow control are outside this block.

Top module: `uart_tx_engine`

## Requirements
- R1: Out of reset, and whenever nothing is being sent, `tx_o` is 1. After reset with an empty FIFO, `done_o` is 1 and `fifo_pop_o` is 0.
- R2: A frame starts on the clock edge at which a byte is popped. `tx_o` goes to 0 on that edge and stays at 0 for one bit period. One bit period is 16 ticks of `div_i` clocks each, which is 16*`div_i` clock cycles.
- R3: In 8-bit mode (`seven_bit_i`=0), the 8 data bits follow the start bit, least significant bit first, each one bit period long.
- R4: In 7-bit mode (`seven_bit_i`=1), only bits 6..0 of the byte are sent, least significant bit first. Bit 7 is never sent.
- R5: `par_sel_i`=1 selects odd parity and `par_sel_i`=2 selects even parity. The parity bit is one bit period long and comes right after the last data bit. `par_sel_i`=0 sends no parity bit.
- R6: `stop_sel_i`=0 gives a stop period of 16 ticks, 1 gives 24 ticks and 2 gives 32 ticks. `tx_o` is 1 for the whole stop period.
- R7: The illegal codes are treated as safe defaults. `stop_sel_i`=3 acts as one stop bit and `par_sel_i`=3 acts as no parity.
- R8: Size, parity and stop settings are captured when the byte is popped. A change to these inputs while a frame is being sent has no effect on that frame.
- R9: `done_o` is 1 only when the FIFO is empty and no frame is in progress. It is 0 from the frame's start edge and goes to 1 on the edge that ends the final stop period.
- R10: If the FIFO is not empty when a stop period ends, the next start bit begins on that same edge. `fifo_pop_o` is a one-cycle pulse, given once per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_i | input | 16 | Tick divisor; tick rate is clock / div_i |
| stop_sel_i | input | 2 | Stop length code: 0 = 1 bit, 1 = 1.5 bits, 2 = 2 bits |
| par_sel_i | input | 2 | Parity code: 0 = none, 1 = odd, 2 = even |
| seven_bit_i | input | 1 | 1 = 7 data bits, 0 = 8 data bits |
| fifo_empty_i | input | 1 | Transmit FIFO is empty |
| fifo_data_i | input | 8 | Byte at the head of the transmit FIFO |
| fifo_pop_o | output | 1 | Takes the head byte from the FIFO on this clock edge |
| tx_o | output | 1 | Serial output line |
| done_o | output | 1 | FIFO empty and engine idle |

## Verification
The start bit appears on the edge after the pop. Taking that edge as cycle zero, bit k of the frame (the start bit is bit 0) is centred at cycle (16k+8)*div. The stop period lasts exactly the selected tick count times div, and it ends with either the next start bit or `done_o` rising. The monitor samples on falling clock edges and counts cycles from the first low level it sees. It checks each bit at its centre cycle and measures the stop period to the exact cycle. An early or late edge, or one missing or extra bit, therefore shows up as a mismatch.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP
  } tx_state_e;

  localparam logic [1:0] STOP_ONE  = 2'd0;
  localparam logic [1:0] STOP_HALF = 2'd1;
  localparam logic [1:0] STOP_TWO  = 2'd2;
  localparam logic [1:0] PAR_NONE  = 2'd0;
  localparam logic [1:0] PAR_ODD   = 2'd1;
  localparam logic [1:0] PAR_EVEN  = 2'd2;
endpackage

// File: rtl/uart_tx_tick.sv
module uart_tx_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             restart_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = (cnt_q == div_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (restart_i || tick_o)  cnt_q <= '0;
    else                           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/uart_tx_fmt.sv
module uart_tx_fmt
  import uart_tx_pkg::*;
#(
  parameter int OSR  = 16,
  parameter int PH_W = 5
) (
  input  logic [1:0]      stop_sel_i,
  input  logic [1:0]      par_sel_i,
  output logic            par_en_o,
  output logic            par_odd_o,
  output logic [PH_W-1:0] stop_last_o
);
  // illegal codes fall back to 1 stop / no parity
  always_comb begin
    case (stop_sel_i)
      STOP_HALF: stop_last_o = PH_W'(OSR + OSR/2 - 1);
      STOP_TWO:  stop_last_o = PH_W'(2*OSR - 1);
      default:   stop_last_o = PH_W'(OSR - 1);
    endcase
    par_en_o  = (par_sel_i == PAR_ODD) || (par_sel_i == PAR_EVEN);
    par_odd_o = (par_sel_i == PAR_ODD);
  end
endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16,
  parameter int PH_W   = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              fifo_empty_i,
  input  logic [DATA_W-1:0] fifo_data_i,
  input  logic              seven_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic [PH_W-1:0]   stop_last_i,
  output logic              pop_o,
  output logic              idle_o,
  output logic              tx_o
);
  localparam int BI_W = $clog2(DATA_W);
  localparam logic [PH_W-1:0] BIT_LAST = PH_W'(OSR - 1);

  tx_state_e         state_q;
  logic [PH_W-1:0]   ph_q, stop_last_q, ph_last;
  logic [BI_W-1:0]   bidx_q, last_q;
  logic [DATA_W-1:0] shr_q, data_m;
  logic              par_q, par_en_q, tx_q, bit_end, frame_end;

  always_comb begin
    data_m = fifo_data_i;
    if (seven_i) data_m[DATA_W-1] = 1'b0;
  end

  assign ph_last   = (state_q == ST_STOP) ? stop_last_q : BIT_LAST;
  assign bit_end   = tick_i && (ph_q == ph_last);
  assign frame_end = bit_end && (state_q == ST_STOP);
  // pop at stop end too, so frames run back to back
  assign pop_o     = !fifo_empty_i && ((state_q == ST_IDLE) || frame_end);
  assign idle_o    = (state_q == ST_IDLE);
  assign tx_o      = tx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      ph_q        <= '0;
      bidx_q      <= '0;
      last_q      <= '0;
      shr_q       <= '0;
      par_q       <= 1'b0;
      par_en_q    <= 1'b0;
      stop_last_q <= '0;
      tx_q        <= 1'b1;
    end else if (pop_o) begin
      state_q     <= ST_START;
      ph_q        <= '0;
      bidx_q      <= '0;
      last_q      <= seven_i ? BI_W'(DATA_W - 2) : BI_W'(DATA_W - 1);
      shr_q       <= data_m;
      par_q       <= par_odd_i ? ~^data_m : ^data_m;
      par_en_q    <= par_en_i;
      stop_last_q <= stop_last_i;
      tx_q        <= 1'b0;
    end else if (tick_i && state_q != ST_IDLE) begin
      if (!bit_end) begin
        ph_q <= ph_q + 1'b1;
      end else begin
        ph_q <= '0;
        case (state_q)
          ST_START: begin
            state_q <= ST_DATA;
            tx_q    <= shr_q[0];
            shr_q   <= shr_q >> 1;
          end
          ST_DATA: begin
            if (bidx_q == last_q) begin
              state_q <= par_en_q ? ST_PAR : ST_STOP;
              tx_q    <= par_en_q ? par_q : 1'b1;
            end else begin
              bidx_q <= bidx_q + 1'b1;
              tx_q   <= shr_q[0];
              shr_q  <= shr_q >> 1;
            end
          end
          ST_PAR: begin
            state_q <= ST_STOP;
            tx_q    <= 1'b1;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_tx_engine.sv
module uart_tx_engine #(
  parameter int DIV_W  = 16,
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [1:0]        stop_sel_i,
  input  logic [1:0]        par_sel_i,
  input  logic              seven_bit_i,
  input  logic              fifo_empty_i,
  input  logic [DATA_W-1:0] fifo_data_i,
  output logic              fifo_pop_o,
  output logic              tx_o,
  output logic              done_o
);
  localparam int PH_W = $clog2(2*OSR);

  logic            tick, idle, par_en, par_odd;
  logic [PH_W-1:0] stop_last;

  uart_tx_tick #(.DIV_W(DIV_W)) u_tick (
    .clk_i, .rst_ni, .div_i,
    .restart_i (fifo_pop_o),
    .tick_o    (tick)
  );

  uart_tx_fmt #(.OSR(OSR), .PH_W(PH_W)) u_fmt (
    .stop_sel_i, .par_sel_i,
    .par_en_o    (par_en),
    .par_odd_o   (par_odd),
    .stop_last_o (stop_last)
  );

  uart_tx_shift #(.DATA_W(DATA_W), .OSR(OSR), .PH_W(PH_W)) u_shift (
    .clk_i, .rst_ni,
    .tick_i       (tick),
    .fifo_empty_i,
    .fifo_data_i,
    .seven_i      (seven_bit_i),
    .par_en_i     (par_en),
    .par_odd_i    (par_odd),
    .stop_last_i  (stop_last),
    .pop_o        (fifo_pop_o),
    .idle_o       (idle),
    .tx_o
  );

  assign done_o = idle && fifo_empty_i;
endmodule

// File: rtl/uart_tx_engine_chk.sv
module uart_tx_engine_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tick_i,
  input logic fifo_pop_o,
  input logic tx_o,
  input logic done_o
);
  AST_DONE_LINE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> tx_o);  // R1

  AST_START_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_pop_o |=> !tx_o);  // R2

  AST_TX_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(tick_i) && !$past(fifo_pop_o)) |-> $stable(tx_o));  // R2

  AST_BUSY_AFTER_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_pop_o |=> !done_o);  // R9

  AST_POP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_pop_o |=> !fifo_pop_o);  // R10
endmodule

bind uart_tx_engine uart_tx_engine_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick),
  .fifo_pop_o (fifo_pop_o),
  .tx_o       (tx_o),
  .done_o     (done_o)
);

// File: tb/uart_tx_engine_tb.sv
module uart_tx_engine_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] div = 16'd2;
  logic [1:0]  stop_sel = 2'd0, par_sel = 2'd0;
  logic        seven = 1'b0;
  logic        fifo_empty, fifo_pop, tx, done;
  logic [7:0]  fifo_data;

  logic [7:0] fifo_mem [0:63];
  logic [5:0] wr_ptr = '0, rd_ptr = '0;
  int         pops = 0, pushed = 0;
  int         checks = 0, errors = 0;
  bit         over = 1'b0;

  typedef struct {
    logic [7:0] d;
    int nb; bit pe; bit pv; int stop_t; int dv;
    string dtag, ptag, stag;
  } exp_t;
  exp_t exp_q[$];

  always #5 clk = ~clk;

  assign fifo_empty = (wr_ptr == rd_ptr);
  assign fifo_data  = fifo_mem[rd_ptr];

  always @(posedge clk) if (fifo_pop) begin
    rd_ptr <= rd_ptr + 1'b1;
    pops   <= pops + 1;
  end

  uart_tx_engine u_dut (
    .clk_i(clk), .rst_ni, .div_i(div), .stop_sel_i(stop_sel), .par_sel_i(par_sel),
    .seven_bit_i(seven), .fifo_empty_i(fifo_empty), .fifo_data_i(fifo_data),
    .fifo_pop_o(fifo_pop), .tx_o(tx), .done_o(done)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, expv, $time);
    end
  endtask

  task automatic finish_run();
    if (!over) begin
      over = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // driver: queue byte for the FIFO and its expected frame for the scoreboard
  task automatic push(input logic [7:0] b, input string tag_all);
    exp_t e;
    e.nb = seven ? 7 : 8;
    e.d  = seven ? (b & 8'h7F) : b;
    e.pe = (par_sel == 2'd1) || (par_sel == 2'd2);
    e.pv = (par_sel == 2'd1) ? ~^e.d : ^e.d;
    e.stop_t = (stop_sel == 2'd1) ? 24 : (stop_sel == 2'd2) ? 32 : 16;
    e.dv = int'(div);
    e.dtag = seven ? "R4" : "R3";
    e.ptag = "R5";
    e.stag = (stop_sel == 2'd3) ? "R7" : "R6";
    if (par_sel == 2'd3) e.ptag = "R7";
    if (tag_all != "") begin e.dtag = tag_all; e.ptag = tag_all; e.stag = tag_all; end
    exp_q.push_back(e);
    fifo_mem[wr_ptr] = b;
    wr_ptr = wr_ptr + 1'b1;
    pushed++;
  endtask

  task automatic wait_drain();
    int g = 0;
    do begin @(negedge clk); g++; end while ((exp_q.size() != 0 || !done) && g < 50000);
    @(negedge clk);
    chk(done === 1'b1 && tx === 1'b1, "R9 drained done/line", {done, tx}, 2'b11);
  endtask

  // monitor: entered on the first negedge with the start bit low (n=0)
  task automatic run_frame();
    exp_t e;
    int n = 0, cnt = 0, ks;
    if (exp_q.size() == 0) begin
      chk(1'b0, "R10 unexpected frame", 0, 1);
      do @(negedge clk); while (tx === 1'b0);
      return;
    end
    e = exp_q.pop_front();
    while (n < 8*e.dv) begin @(negedge clk); n++; end
    chk(tx === 1'b0, "R2 start bit", tx, 0);
    for (int i = 0; i < e.nb; i++) begin
      while (n < (16*(i+1)+8)*e.dv) begin @(negedge clk); n++; end
      chk(tx === e.d[i], {e.dtag, " data bit"}, tx, e.d[i]);
    end
    if (e.pe) begin
      while (n < (16*(e.nb+1)+8)*e.dv) begin @(negedge clk); n++; end
      chk(tx === e.pv, {e.ptag, " parity bit"}, tx, e.pv);
    end
    ks = 1 + e.nb + int'(e.pe);
    while (n < 16*ks*e.dv) begin @(negedge clk); n++; end
    while (tx === 1'b1 && done !== 1'b1 && cnt < 100000) begin @(negedge clk); cnt++; end
    chk(cnt == e.stop_t*e.dv, {e.stag, " stop length cycles"}, cnt, e.stop_t*e.dv);
  endtask

  initial begin : monitor
    @(posedge rst_ni);
    forever begin
      @(negedge clk);
      while (tx === 1'b0) run_frame();
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    chk(tx === 1'b1 && done === 1'b1 && fifo_pop === 1'b0, "R1 in reset", {tx, done, fifo_pop}, 3'b110);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk);
    chk(tx === 1'b1 && done === 1'b1 && fifo_pop === 1'b0, "R1 after reset", {tx, done, fifo_pop}, 3'b110);

    // 8N1, back to back
    div = 16'd2; seven = 0; par_sel = 2'd0; stop_sel = 2'd0;
    push(8'hA5, ""); push(8'h3C, "");
    @(negedge clk);
    chk(done === 1'b0, "R9 busy after push", done, 0);
    wait_drain();

    // 7 bits, even parity, two stops
    seven = 1; par_sel = 2'd2; stop_sel = 2'd2;
    push(8'hFF, ""); push(8'h81, ""); push(8'h80, "");
    wait_drain();

    // 8 bits, odd parity, 1.5 stops
    div = 16'd3; seven = 0; par_sel = 2'd1; stop_sel = 2'd1;
    push(8'h00, ""); push(8'h7E, "");
    wait_drain();

    // illegal codes
    div = 16'd1; par_sel = 2'd3; stop_sel = 2'd3;
    push(8'hC3, ""); push(8'h5A, "");
    wait_drain();

    // format change mid-frame has no effect on the current frame
    div = 16'd2; seven = 0; par_sel = 2'd0; stop_sel = 2'd0;
    push(8'hD5, "R8");
    while (!fifo_empty) @(negedge clk);
    repeat (20) @(negedge clk);
    seven = 1; par_sel = 2'd2; stop_sel = 2'd2;
    wait_drain();
    push(8'hD5, "");
    wait_drain();

    chk(pops == pushed, "R10 one pop per frame", pops, pushed);
    chk(exp_q.size() == 0, "R10 all frames seen", exp_q.size(), 0);
    finish_run();
  end
endmodule